// File: doc/BRIEF.md
# I2C Transfer Chunking Sequencer

This block sits between a host that describes an I2C transaction as a list of messages and a byte-level master engine whose data buffer holds only four bytes. The host presents up to `MAX_MSGS` message descriptors at once (target address, address width, direction and signed length per message, plus a message count) and pulses `startReq`. The sequencer latches the descriptors and checks them before any bus activity. It then forms the address bytes and walks each message in chunks no larger than the buffer. For each chunk it issues one command word to the engine, carrying the byte count, a chain flag, a repeated-start flag and the direction.

For write messages the chunk's bytes are pulled from the host transmit stream into the engine buffer before the command goes out. For read messages the engine's buffer is drained to the host receive stream once the engine reports completion. The engine's reported byte count is compared with the request. A short count ends the transaction. In that case an abort command is sent, except when the short chunk was the very last one. An engine error ends the transaction at once. Each transaction finishes with a single `doneValid` pulse carrying a two-bit result code.

Top module: `i2c_chunk_seq`

## Requirements
- R1: A message of length L is issued as ceil(L/4) commands, each carrying min(4, bytes remaining) bytes. `cmdCount` is that byte count minus one.
- R2: `cmdChain` is 1 on every command of a message except the last one of that message.
- R3: `cmdRptStart` is 1 only on the last command of a message that is not the final message. The final command of a transaction has both flags 0.
- R4: For a write message (`msgRead` bit 0), exactly the chunk's bytes are moved from `txData` to the buffer (`txPop`/`bufWrEn`) before its command, and `cmdRead` is 0. For a read message (bit 1), no buffer writes occur and `cmdRead` is 1. After a completion with the full count, exactly the chunk's bytes are drained in order to `rxData` with `rxValid`.
- R5: For a 7-bit address, `engAddrLo` is addr shifted left by one, `engAddrHi` is 0 and `engTenBit` is 0. For a 10-bit address, `engAddrLo` is addr[7:0], `engAddrHi` is 0xF0 OR ((addr >> 7) AND 0x06) and `engTenBit` is 1. These values are valid from the first command on.
- R6: A transaction is rejected with result 1 and no command, abort or buffer traffic in any of three cases: a message length is zero or negative (MSB of its `LENW`-bit field set); a message's address or address width differs from message 0; or message 0 is 7-bit with an address above 0x7F.
- R7: If `engXferCnt` differs from the chunk byte count, the transaction ends with result 2 and no further commands. One `abortCmd` pulse precedes `doneValid`, unless the chunk was the final chunk of the final message.
- R8: An `engDone` with `engErr` set ends the transaction with result 3. No abort and no further command follow.
- R9: Every `startReq` accepted while idle yields exactly one `doneValid`, and `busy` is low the cycle after. A transaction with `numMsgs` = 0 ends with result 0 and no bus activity. A successful transaction ends with result 0.
- R10: After reset, `busy`, `doneValid`, `cmdValid`, `abortCmd`, `bufWrEn` and `bufRdEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start a transaction (sampled while idle) |
| numMsgs | input | NUMW | Number of messages in the transaction |
| msgAddr | input | MAX_MSGS*10 | Per-message target address, message i at bits [10i+9:10i] |
| msgTenBit | input | MAX_MSGS | Per-message 10-bit address select |
| msgRead | input | MAX_MSGS | Per-message direction, 1 = read |
| msgLen | input | MAX_MSGS*LENW | Per-message signed byte length |
| busy | output | 1 | Transaction in progress |
| doneValid | output | 1 | One-cycle end-of-transaction pulse |
| doneStatus | output | 2 | Result: 0 ok, 1 rejected, 2 short count, 3 engine error |
| engAddrLo | output | 8 | Low address byte to the engine |
| engAddrHi | output | 8 | High address byte to the engine |
| engTenBit | output | 1 | 10-bit addressing enable to the engine |
| cmdValid | output | 1 | Command strobe to the engine |
| cmdCount | output | CNTW | Chunk byte count minus one |
| cmdChain | output | 1 | Hold the bus, no STOP after this chunk |
| cmdRptStart | output | 1 | End the chunk with a repeated START |
| cmdRead | output | 1 | Chunk direction, 1 = read |
| abortCmd | output | 1 | Abort request to the engine |
| engDone | input | 1 | Engine completion pulse |
| engErr | input | 1 | Engine error, valid with engDone |
| engXferCnt | input | CHW | Bytes the engine transferred, valid with engDone |
| bufWrEn | output | 1 | Write one byte to the engine buffer |
| bufWrData | output | 8 | Byte written to the engine buffer |
| bufRdEn | output | 1 | Pop one byte from the engine buffer |
| bufRdData | input | 8 | Head byte of the engine buffer |
| txPop | output | 1 | Consume the head of the transmit stream |
| txData | input | 8 | Head byte of the transmit stream |
| rxValid | output | 1 | Received byte strobe |
| rxData | output | 8 | Received byte |

## Verification
A wrong remaining-byte count or message index shows up at the first command whose count, chain or repeated-start field is derived from it. That is at most one chunk, about ten cycles, after the corruption. A miscounted byte index in the load or drain phase shows up before the next command, as a mismatch between the number of buffer strobes and the command count, or as a stream byte out of order. Faults in result handling appear as a wrong code on `doneValid`, or as a missing or extra `abortCmd` directly before it. The bench compares these against a command list computed from the descriptors, with short counts and engine errors injected at chosen chunks.

// File: rtl/i2c_chunk_pkg.sv
package i2c_chunk_pkg;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_REJECT = 2'd1,
    RES_SHORT  = 2'd2,
    RES_ENGERR = 2'd3
  } result_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_SETUP, S_LOAD, S_ISSUE,
    S_WAIT, S_DRAIN, S_ADVANCE, S_ABORT, S_FINISH
  } seq_state_e;

  // control -> datapath
  typedef struct packed {
    logic    latch;
    logic    loadMsg;
    logic    setChunk;
    logic    stepByte;
    logic    advance;
    logic    setResult;
    result_e result;
  } seq_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic noMsgs;
    logic invalid;
    logic isRead;
    logic lastByte;
    logic countOk;
    logic finalChunk;
  } seq_flag_t;

endpackage

// File: rtl/chunk_datapath.sv
module chunk_datapath
  import i2c_chunk_pkg::*;
#(
  parameter int MAX_MSGS  = 4,
  parameter int LENW      = 8,
  parameter int BUF_DEPTH = 4,
  localparam int NUMW = $clog2(MAX_MSGS + 1),
  localparam int IDXW = $clog2(MAX_MSGS),
  localparam int CHW  = $clog2(BUF_DEPTH + 1),
  localparam int CNTW = $clog2(BUF_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seq_strobe_t              strb,
  output seq_flag_t                flags,
  input  logic [NUMW-1:0]          numMsgs,
  input  logic [MAX_MSGS*10-1:0]   msgAddr,
  input  logic [MAX_MSGS-1:0]      msgTenBit,
  input  logic [MAX_MSGS-1:0]      msgRead,
  input  logic [MAX_MSGS*LENW-1:0] msgLen,
  input  logic [CHW-1:0]           engXferCnt,
  output logic [7:0]               engAddrLo,
  output logic [7:0]               engAddrHi,
  output logic                     engTenBit,
  output logic [CNTW-1:0]          cmdCount,
  output logic                     cmdChain,
  output logic                     cmdRptStart,
  output logic                     cmdRead,
  output logic [1:0]               doneStatus
);

  logic [NUMW-1:0] numR;
  logic [9:0]      addrR [MAX_MSGS];
  logic [LENW-1:0] lenR  [MAX_MSGS];
  logic [MAX_MSGS-1:0] tenR, readR;

  logic [LENW-1:0] remaining;
  logic [IDXW-1:0] msgIdx;
  logic [CHW-1:0]  chunkSize;
  logic [CHW-1:0]  byteIdx;
  result_e         resultR;

  logic            lastMsg, msgDone, bad;
  logic [IDXW-1:0] nextIdx;
  logic [CHW-1:0]  sizeMinusOne;

  // descriptor latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numR  <= '0;
      tenR  <= '0;
      readR <= '0;
      for (int i = 0; i < MAX_MSGS; i++) begin
        addrR[i] <= '0;
        lenR[i]  <= '0;
      end
    end else if (strb.latch) begin
      numR  <= numMsgs;
      tenR  <= msgTenBit;
      readR <= msgRead;
      for (int i = 0; i < MAX_MSGS; i++) begin
        addrR[i] <= msgAddr[i*10 +: 10];
        lenR[i]  <= msgLen[i*LENW +: LENW];
      end
    end
  end

  // request validation over the active descriptors
  always_comb begin
    bad = !tenR[0] && (addrR[0] > 10'h07F);
    for (int i = 0; i < MAX_MSGS; i++) begin
      if (i < int'(numR)) begin
        if (lenR[i][LENW-1] || lenR[i] == '0) bad = 1'b1;
        if (addrR[i] != addrR[0] || tenR[i] != tenR[0]) bad = 1'b1;
      end
    end
  end

  // chunk walk
  assign nextIdx = msgIdx + IDXW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      msgIdx    <= '0;
      chunkSize <= '0;
      byteIdx   <= '0;
      resultR   <= RES_OK;
    end else begin
      if (strb.loadMsg) begin
        remaining <= lenR[0];
        msgIdx    <= '0;
      end
      if (strb.setChunk) begin
        chunkSize <= (remaining > LENW'(BUF_DEPTH)) ? CHW'(BUF_DEPTH)
                                                    : remaining[CHW-1:0];
        byteIdx   <= '0;
      end
      if (strb.stepByte) byteIdx <= byteIdx + CHW'(1);
      if (strb.advance) begin
        if (msgDone) begin
          msgIdx    <= nextIdx;
          remaining <= lenR[nextIdx];
        end else begin
          remaining <= remaining - LENW'(chunkSize);
        end
      end
      if (strb.setResult) resultR <= strb.result;
    end
  end

  assign lastMsg      = (int'(msgIdx) + 1) == int'(numR);
  assign msgDone      = remaining == LENW'(chunkSize);
  assign sizeMinusOne = chunkSize - CHW'(1);

  assign flags.noMsgs     = numR == '0;
  assign flags.invalid    = bad;
  assign flags.isRead     = readR[msgIdx];
  assign flags.lastByte   = byteIdx == sizeMinusOne;
  assign flags.countOk    = engXferCnt == chunkSize;
  assign flags.finalChunk = lastMsg && msgDone;

  // command word
  assign cmdCount    = sizeMinusOne[CNTW-1:0];
  assign cmdChain    = !msgDone;
  assign cmdRptStart = msgDone && !lastMsg;
  assign cmdRead     = readR[msgIdx];

  // address bytes
  assign engTenBit = tenR[0];
  assign engAddrLo = tenR[0] ? addrR[0][7:0] : {addrR[0][6:0], 1'b0};
  assign engAddrHi = tenR[0] ? {4'hF, 1'b0, addrR[0][9:8], 1'b0} : 8'h00;

  assign doneStatus = resultR;

endmodule

// File: rtl/chunk_control.sv
module chunk_control
  import i2c_chunk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  seq_flag_t   flags,
  input  logic        engDone,
  input  logic        engErr,
  output seq_strobe_t strb,
  output logic        busy,
  output logic        cmdValid,
  output logic        abortCmd,
  output logic        wrByte,
  output logic        rdByte,
  output logic        doneValid
);

  seq_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    cmdValid  = 1'b0;
    abortCmd  = 1'b0;
    wrByte    = 1'b0;
    rdByte    = 1'b0;
    doneValid = 1'b0;
    unique case (state)
      S_IDLE: if (startReq) begin
        strb.latch = 1'b1;
        nextState  = S_CHECK;
      end
      S_CHECK: begin
        if (flags.noMsgs || flags.invalid) begin
          strb.setResult = 1'b1;
          strb.result    = flags.noMsgs ? RES_OK : RES_REJECT;
          nextState      = S_FINISH;
        end else begin
          strb.loadMsg = 1'b1;
          nextState    = S_SETUP;
        end
      end
      S_SETUP: begin
        strb.setChunk = 1'b1;
        nextState     = flags.isRead ? S_ISSUE : S_LOAD;
      end
      S_LOAD: begin
        wrByte        = 1'b1;
        strb.stepByte = 1'b1;
        if (flags.lastByte) nextState = S_ISSUE;
      end
      S_ISSUE: begin
        cmdValid  = 1'b1;
        nextState = S_WAIT;
      end
      S_WAIT: if (engDone) begin
        if (engErr) begin
          strb.setResult = 1'b1;
          strb.result    = RES_ENGERR;
          nextState      = S_FINISH;
        end else if (!flags.countOk) begin
          strb.setResult = 1'b1;
          strb.result    = RES_SHORT;
          nextState      = flags.finalChunk ? S_FINISH : S_ABORT;
        end else begin
          nextState = flags.isRead ? S_DRAIN : S_ADVANCE;
        end
      end
      S_DRAIN: begin
        rdByte        = 1'b1;
        strb.stepByte = 1'b1;
        if (flags.lastByte) nextState = S_ADVANCE;
      end
      S_ADVANCE: begin
        if (flags.finalChunk) begin
          strb.setResult = 1'b1;
          strb.result    = RES_OK;
          nextState      = S_FINISH;
        end else begin
          strb.advance = 1'b1;
          nextState    = S_SETUP;
        end
      end
      S_ABORT: begin
        abortCmd  = 1'b1;
        nextState = S_FINISH;
      end
      S_FINISH: begin
        doneValid = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = state != S_IDLE;

endmodule

// File: rtl/i2c_chunk_seq.sv
module i2c_chunk_seq
  import i2c_chunk_pkg::*;
#(
  parameter int MAX_MSGS  = 4,
  parameter int LENW      = 8,
  parameter int BUF_DEPTH = 4,
  localparam int NUMW = $clog2(MAX_MSGS + 1),
  localparam int CHW  = $clog2(BUF_DEPTH + 1),
  localparam int CNTW = $clog2(BUF_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic [NUMW-1:0]          numMsgs,
  input  logic [MAX_MSGS*10-1:0]   msgAddr,
  input  logic [MAX_MSGS-1:0]      msgTenBit,
  input  logic [MAX_MSGS-1:0]      msgRead,
  input  logic [MAX_MSGS*LENW-1:0] msgLen,
  output logic                     busy,
  output logic                     doneValid,
  output logic [1:0]               doneStatus,
  output logic [7:0]               engAddrLo,
  output logic [7:0]               engAddrHi,
  output logic                     engTenBit,
  output logic                     cmdValid,
  output logic [CNTW-1:0]          cmdCount,
  output logic                     cmdChain,
  output logic                     cmdRptStart,
  output logic                     cmdRead,
  output logic                     abortCmd,
  input  logic                     engDone,
  input  logic                     engErr,
  input  logic [CHW-1:0]           engXferCnt,
  output logic                     bufWrEn,
  output logic [7:0]               bufWrData,
  output logic                     bufRdEn,
  input  logic [7:0]               bufRdData,
  output logic                     txPop,
  input  logic [7:0]               txData,
  output logic                     rxValid,
  output logic [7:0]               rxData
);

  seq_strobe_t strb;
  seq_flag_t   flags;
  logic        wrByte, rdByte;

  chunk_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .flags    (flags),
    .engDone  (engDone),
    .engErr   (engErr),
    .strb     (strb),
    .busy     (busy),
    .cmdValid (cmdValid),
    .abortCmd (abortCmd),
    .wrByte   (wrByte),
    .rdByte   (rdByte),
    .doneValid(doneValid)
  );

  chunk_datapath #(
    .MAX_MSGS (MAX_MSGS),
    .LENW     (LENW),
    .BUF_DEPTH(BUF_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .flags      (flags),
    .numMsgs    (numMsgs),
    .msgAddr    (msgAddr),
    .msgTenBit  (msgTenBit),
    .msgRead    (msgRead),
    .msgLen     (msgLen),
    .engXferCnt (engXferCnt),
    .engAddrLo  (engAddrLo),
    .engAddrHi  (engAddrHi),
    .engTenBit  (engTenBit),
    .cmdCount   (cmdCount),
    .cmdChain   (cmdChain),
    .cmdRptStart(cmdRptStart),
    .cmdRead    (cmdRead),
    .doneStatus (doneStatus)
  );

  assign bufWrEn   = wrByte;
  assign txPop     = wrByte;
  assign bufWrData = txData;
  assign bufRdEn   = rdByte;
  assign rxValid   = rdByte;
  assign rxData    = bufRdData;

endmodule

// File: rtl/chunk_seq_checker.sv
module chunk_seq_checker #(
  parameter int BUF_DEPTH = 4,
  localparam int CNTW = $clog2(BUF_DEPTH)
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            doneValid,
  input logic [1:0]      doneStatus,
  input logic            cmdValid,
  input logic [CNTW-1:0] cmdCount,
  input logic            cmdChain,
  input logic            cmdRptStart,
  input logic            abortCmd,
  input logic            bufWrEn,
  input logic            bufRdEn
);

  AST_CHAIN_IS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdChain |-> cmdCount == CNTW'(BUF_DEPTH - 1)); // R2

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !(cmdChain && cmdRptStart)); // R3

  AST_BUF_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    !(bufWrEn && bufRdEn)); // R4

  AST_ABORT_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    abortCmd |=> doneValid && doneStatus == 2'd2); // R7

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !busy); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid && !abortCmd && !bufWrEn && !bufRdEn && !doneValid); // R10

endmodule

bind i2c_chunk_seq chunk_seq_checker #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .doneValid  (doneValid),
  .doneStatus (doneStatus),
  .cmdValid   (cmdValid),
  .cmdCount   (cmdCount),
  .cmdChain   (cmdChain),
  .cmdRptStart(cmdRptStart),
  .abortCmd   (abortCmd),
  .bufWrEn    (bufWrEn),
  .bufRdEn    (bufRdEn)
);

// File: tb/sim_i2c_chunk_seq.sv
module sim_i2c_chunk_seq;
  localparam int MAX_MSGS = 4;
  localparam int LENW = 8;
  localparam int BUF_DEPTH = 4;
  localparam int NUMW = 3;
  localparam int CHW = 3;
  localparam int CNTW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [NUMW-1:0] numMsgs = '0;
  logic [MAX_MSGS*10-1:0] msgAddr = '0;
  logic [MAX_MSGS-1:0] msgTenBit = '0, msgRead = '0;
  logic [MAX_MSGS*LENW-1:0] msgLen = '0;
  logic busy, doneValid, engTenBit, cmdValid, cmdChain, cmdRptStart, cmdRead, abortCmd;
  logic [1:0] doneStatus;
  logic [7:0] engAddrLo, engAddrHi, bufWrData, bufRdData, txData, rxData;
  logic [CNTW-1:0] cmdCount;
  logic engDone = 1'b0, engErr = 1'b0;
  logic [CHW-1:0] engXferCnt = '0;
  logic bufWrEn, bufRdEn, txPop, rxValid;

  always #10 clk = ~clk;

  i2c_chunk_seq u0 (.*);

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] txPat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] rdPat(input int k);
    return 8'((k * 53 + 200) & 255);
  endfunction

  // stream and buffer sources
  int txPtr = 0, rdPtr = 0;
  assign txData    = txPat(txPtr);
  assign bufRdData = rdPat(rdPtr);
  always @(posedge clk) begin
    if (txPop) txPtr <= txPtr + 1;
    if (bufRdEn) rdPtr <= rdPtr + 1;
  end

  // engine model
  int faultKind = 0, faultAt = -1;
  int engWait = 0, engChunk = 0, engThis = 0, engBytes = 0;
  always @(posedge clk) begin
    engDone <= 1'b0;
    engErr  <= 1'b0;
    if (startReq) engChunk <= 0;
    if (cmdValid) begin
      engWait  <= 3;
      engBytes <= int'(cmdCount) + 1;
      engThis  <= engChunk;
      engChunk <= engChunk + 1;
    end else if (engWait > 0) begin
      engWait <= engWait - 1;
      if (engWait == 1) begin
        engDone    <= 1'b1;
        engXferCnt <= CHW'((faultKind == 1 && engThis == faultAt) ? engBytes - 1 : engBytes);
        engErr     <= (faultKind == 2 && engThis == faultAt);
      end
    end
  end

  // transaction description and expectations
  int tNum;
  int tLen [MAX_MSGS];
  int tAddr [MAX_MSGS];
  bit tTen [MAX_MSGS];
  bit tRd [MAX_MSGS];
  int expN, expStat, expAbort, expWr, expRx, expLo, expHi, expTen;
  int expCount [64];
  bit expChain [64], expRpt [64], expRead [64];

  task automatic planTxn();
    bit bad;
    bit stop;
    int g;
    expN = 0; expAbort = 0; expWr = 0; expRx = 0; expStat = 0;
    if (tTen[0]) begin
      expLo = tAddr[0] & 255; expHi = 8'hF0 | ((tAddr[0] >> 7) & 6); expTen = 1;
    end else begin
      expLo = (tAddr[0] << 1) & 255; expHi = 0; expTen = 0;
    end
    bad = !tTen[0] && tAddr[0] > 127;
    for (int i = 0; i < tNum; i++)
      if (tLen[i] <= 0 || tAddr[i] != tAddr[0] || tTen[i] != tTen[0]) bad = 1;
    if (tNum == 0) return;
    if (bad) begin expStat = 1; return; end
    g = 0; stop = 0;
    for (int m = 0; m < tNum && !stop; m++) begin
      int rem = tLen[m];
      while (rem > 0 && !stop) begin
        int sz = rem > 4 ? 4 : rem;
        expCount[g] = sz;
        expChain[g] = rem > 4;
        expRpt[g]   = (rem <= 4) && (m != tNum - 1);
        expRead[g]  = tRd[m];
        if (!tRd[m]) expWr += sz;
        if (faultKind == 1 && g == faultAt) begin
          expStat = 2;
          expAbort = ((rem <= 4) && (m == tNum - 1)) ? 0 : 1;
          stop = 1;
        end else if (faultKind == 2 && g == faultAt) begin
          expStat = 3;
          stop = 1;
        end else if (tRd[m]) expRx += sz;
        rem -= sz;
        g++;
      end
    end
    expN = g;
  endtask

  // port monitor
  int cmdSeen = 0, wrTxn = 0, rxTxn = 0, abortSeen = 0, wrChunk = 0, wrSeen = 0, rxSeen = 0;
  bit doneSeen = 0;
  int doneStat = 0;
  always @(negedge clk) begin
    if (startReq) begin
      cmdSeen = 0; wrTxn = 0; rxTxn = 0; abortSeen = 0; wrChunk = 0;
    end
    if (bufWrEn) begin
      chk(bufWrData == txPat(wrSeen), "R4", "buffer write byte", int'(bufWrData), int'(txPat(wrSeen)));
      wrSeen++; wrTxn++; wrChunk++;
    end
    if (bufRdEn) begin
      chk(rxValid && rxData == rdPat(rxSeen), "R4", "received byte", int'(rxData), int'(rdPat(rxSeen)));
      rxSeen++; rxTxn++;
    end
    if (cmdValid) begin
      if (cmdSeen < expN) begin
        chk(int'(cmdCount) + 1 == expCount[cmdSeen], "R1", "chunk bytes", int'(cmdCount) + 1, expCount[cmdSeen]);
        chk(cmdChain == expChain[cmdSeen], "R2", "chain flag", int'(cmdChain), int'(expChain[cmdSeen]));
        chk(cmdRptStart == expRpt[cmdSeen], "R3", "repeated-start flag", int'(cmdRptStart), int'(expRpt[cmdSeen]));
        chk(cmdRead == expRead[cmdSeen], "R4", "direction", int'(cmdRead), int'(expRead[cmdSeen]));
        chk(wrChunk == (cmdRead ? 0 : int'(cmdCount) + 1), "R4", "bytes loaded before command", wrChunk, cmdRead ? 0 : int'(cmdCount) + 1);
      end else
        chk(0, "R6", "unexpected command", cmdSeen + 1, expN);
      if (cmdSeen == 0) begin
        chk(engAddrLo == 8'(expLo), "R5", "low address byte", int'(engAddrLo), expLo);
        chk(engAddrHi == 8'(expHi), "R5", "high address byte", int'(engAddrHi), expHi);
        chk(engTenBit == expTen[0], "R5", "ten-bit enable", int'(engTenBit), expTen);
      end
      wrChunk = 0;
      cmdSeen++;
    end
    if (abortCmd) abortSeen++;
    if (doneValid) begin doneSeen = 1; doneStat = int'(doneStatus); end
  end

  task automatic runTxn(input string name);
    string req;
    planTxn();
    @(posedge clk); #1;
    numMsgs = NUMW'(tNum);
    for (int i = 0; i < MAX_MSGS; i++) begin
      msgAddr[i*10 +: 10]    = 10'(tAddr[i]);
      msgTenBit[i]           = tTen[i];
      msgRead[i]             = tRd[i];
      msgLen[i*LENW +: LENW] = LENW'(tLen[i]);
    end
    doneSeen = 0;
    startReq = 1'b1;
    @(posedge clk); #1;
    startReq = 1'b0;
    while (!doneSeen) @(negedge clk);
    case (expStat)
      1: req = "R6";
      2: req = "R7";
      3: req = "R8";
      default: req = "R9";
    endcase
    chk(doneStat == expStat, req, {name, " result"}, doneStat, expStat);
    chk(cmdSeen == expN, req, {name, " command count"}, cmdSeen, expN);
    chk(abortSeen == expAbort, "R7", {name, " aborts"}, abortSeen, expAbort);
    chk(wrTxn == expWr, "R4", {name, " bytes written"}, wrTxn, expWr);
    chk(rxTxn == expRx, "R4", {name, " bytes received"}, rxTxn, expRx);
    @(negedge clk);
    chk(!busy && !doneValid, "R9", {name, " idle after done"}, int'(busy), 0);
  endtask

  task automatic setMsg(input int i, input int len, input bit rd, input int addr, input bit ten);
    tLen[i] = len; tRd[i] = rd; tAddr[i] = addr; tTen[i] = ten;
  endtask

  task automatic clearTxn();
    for (int i = 0; i < MAX_MSGS; i++) setMsg(i, 0, 0, 0, 0);
    tNum = 0; faultKind = 0; faultAt = -1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    clearTxn();
    repeat (3) @(negedge clk);
    chk(!busy && !doneValid && !cmdValid && !abortCmd && !bufWrEn && !bufRdEn, "R10", "quiet in reset", int'(busy), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !doneValid && !cmdValid, "R10", "quiet after reset", int'(busy), 0);

    clearTxn(); runTxn("R9 zero messages");
    clearTxn(); tNum = 1; setMsg(0, 4, 0, 8'h50, 0); runTxn("R1 single full write");
    clearTxn(); tNum = 1; setMsg(0, 5, 1, 8'h21, 0); runTxn("R1 five byte read");
    clearTxn(); tNum = 2; setMsg(0, 3, 0, 10'h3A5, 1); setMsg(1, 9, 1, 10'h3A5, 1); runTxn("R5 ten-bit combined");
    clearTxn(); tNum = 3; setMsg(0, 8, 0, 7, 0); setMsg(1, 1, 1, 7, 0); setMsg(2, 4, 1, 7, 0); runTxn("R3 three messages");
    clearTxn(); tNum = 2; setMsg(0, 2, 0, 9, 0); setMsg(1, 0, 1, 9, 0); runTxn("R6 zero length");
    clearTxn(); tNum = 1; setMsg(0, -3, 0, 9, 0); runTxn("R6 negative length");
    clearTxn(); tNum = 1; setMsg(0, 2, 0, 8'h80, 0); runTxn("R6 seven-bit address too large");
    clearTxn(); tNum = 2; setMsg(0, 2, 0, 9, 0); setMsg(1, 2, 0, 9, 1); runTxn("R6 width mismatch");
    clearTxn(); tNum = 2; setMsg(0, 2, 0, 9, 0); setMsg(1, 2, 0, 10, 0); runTxn("R6 address mismatch");
    clearTxn(); tNum = 1; setMsg(0, 6, 1, 3, 0); faultKind = 1; faultAt = 1; runTxn("R7 short on final chunk");
    clearTxn(); tNum = 2; setMsg(0, 6, 0, 3, 0); setMsg(1, 2, 1, 3, 0); faultKind = 1; faultAt = 0; runTxn("R7 short mid transaction");
    clearTxn(); tNum = 2; setMsg(0, 4, 1, 3, 0); setMsg(1, 2, 0, 3, 0); faultKind = 1; faultAt = 0; runTxn("R7 short at message end");
    clearTxn(); tNum = 2; setMsg(0, 6, 0, 3, 0); setMsg(1, 5, 1, 3, 0); faultKind = 2; faultAt = 2; runTxn("R8 engine error");

    for (int n = 0; n < 150; n++) begin
      int addr;
      bit ten;
      int r;
      clearTxn();
      tNum = 1 + int'($urandom % 4);
      ten  = bit'($urandom % 2);
      addr = ten ? int'($urandom % 1024) : int'($urandom % 128);
      for (int i = 0; i < tNum; i++) setMsg(i, 1 + int'($urandom % 20), bit'($urandom % 2), addr, ten);
      r = int'($urandom % 10);
      if (r == 0) tLen[int'($urandom % tNum)] = 0;
      else if (r == 1 && tNum > 1) tAddr[tNum - 1] = addr ^ 1;
      r = int'($urandom % 6);
      if (r < 2) begin faultKind = r + 1; faultAt = int'($urandom % 8); end
      runTxn("R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule